// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with Decode Mode

This block keeps eight single-bit storage cells, each written on its own. A 3-bit address selects the cell, and a data bit supplies the value. Two active-low controls, an enable and a clear, pick one of four modes:

- **Write:** the selected cell takes the data bit.
- **Hold:** every cell keeps its value.
- **Decode:** the eight outputs act as a 3-to-8 demultiplexer of the data bit.
- **Clear:** every output is forced low.

The storage cells update on the rising clock edge. In decode and clear modes the outputs respond within the same cycle.

Typical uses are serial-to-parallel loading of control bits, one bit per cycle, and a one-hot select that is gated by the data bit. A synchronous active-high system reset also clears all cells.

Top module: `addr_latch`

## Requirements
- R1: The mode comes from (en_n, clr_n): (0,1) is write, (1,1) is hold, (0,0) is decode and (1,0) is clear.
- R2: In write mode, at the rising edge the cell at `addr` takes the value of `din`. Output bit `q[addr]` shows that value from the edge on.
- R3: In write mode, every cell other than the one at `addr` keeps its value across the edge.
- R4: In hold mode, all eight cells keep their values whatever `din` and `addr` do.
- R5: In decode mode, in the same cycle, `q[addr]` equals `din` and all other bits of `q` are 0.
- R6: Decode mode clears every cell at the rising edge, so a later return to hold mode shows `q` = 0.
- R7: In clear mode, `q` is 0 in the same cycle whatever `din` and `addr` are, and every cell is 0 after the edge.
- R8: A high `rst` at a rising edge clears every cell whatever the mode, so `q` reads 0 in the following hold cycle.
- R9: In write and hold modes, `q` shows the stored cells and not `din`. A write becomes visible only after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; cells update on the rising edge |
| rst | input | 1 | Synchronous active-high system reset |
| din | input | 1 | Data bit to store or to route |
| addr | input | 3 | Cell / output select |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear |
| q | output | 8 | Active-high outputs |

## Verification
The bench runs every mode at every address with random data, and compares `q` against a bench model before and after each edge.

Each corner case targets a specific fault:
- A write that leaks into a neighbouring cell would break R3.
- Outputs that pass `din` through in write mode would show a write before its edge and break R9.
- A decode mode that leaves the cells untouched would show stale ones on return to hold and break R6.
- A clear or decode that depends on the address would leave a stray bit high.

A reset asserted during write mode shows whether reset truly dominates.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE  = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_DECODE = 2'd2,
    MODE_CLEAR  = 2'd3
  } mode_e;
endpackage

// File: rtl/mode_decode.sv
module mode_decode
  import addr_latch_pkg::*;
(
  input  logic  en_n,
  input  logic  clr_n,
  output mode_e mode
);
  always_comb begin
    unique case ({en_n, clr_n})
      2'b01:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DECODE;
      default: mode = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/cell_bank.sv
module cell_bank
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NB = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  mode_e             mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic [NB-1:0]     cells
);
  logic wipe;
  assign wipe = (mode == MODE_DECODE) || (mode == MODE_CLEAR);

  for (genvar i = 0; i < NB; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst || wipe)
        cells[i] <= 1'b0;
      else if (mode == MODE_WRITE && addr == ADDR_W'(i))
        cells[i] <= din;
    end
  end

  // R2
  write_hit_chk: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_WRITE |=> cells[$past(addr)] == $past(din));

  // R3
  write_others_chk: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_WRITE |=>
      ((cells ^ $past(cells)) & ~(NB'(1) << $past(addr))) == '0);

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_HOLD |=> $stable(cells));

  // R6
  wipe_cells_chk: assert property (@(posedge clk) disable iff (rst)
    wipe |=> cells == '0);
endmodule

// File: rtl/out_select.sv
module out_select
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NB = 1 << ADDR_W
) (
  input  mode_e             mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  input  logic [NB-1:0]     cells,
  output logic [NB-1:0]     q
);
  logic [NB-1:0] onehot;

  always_comb begin
    onehot = '0;
    onehot[addr] = din;
    unique case (mode)
      MODE_DECODE: q = onehot;
      MODE_CLEAR:  q = '0;
      default:     q = cells;
    endcase
  end
endmodule

// File: rtl/addr_latch.sv
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NB = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_n,
  input  logic              clr_n,
  output logic [NB-1:0]     q
);
  mode_e         mode;
  logic [NB-1:0] cells;

  mode_decode u_mode (
    .en_n  (en_n),
    .clr_n (clr_n),
    .mode  (mode)
  );

  cell_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .addr  (addr),
    .din   (din),
    .cells (cells)
  );

  out_select #(.ADDR_W(ADDR_W)) u_sel (
    .mode  (mode),
    .addr  (addr),
    .din   (din),
    .cells (cells),
    .q     (q)
  );

  // R5
  decode_route_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr_n) |-> ($onehot0(q) && q[addr] == din));

  // R7
  clear_out_chk: assert property (@(posedge clk) disable iff (rst)
    (en_n && !clr_n) |-> q == '0);

  // R9
  write_shows_cells_chk: assert property (@(posedge clk) disable iff (rst)
    clr_n |-> q == cells);
endmodule

// File: tb/addr_latch_test.sv
module addr_latch_test;
  localparam int CLK_P = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic [2:0] addr = '0;
  logic       en_n = 1'b1;
  logic       clr_n = 1'b1;
  logic [7:0] q;

  logic [7:0] model = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  addr_latch uut (
    .clk(clk), .rst(rst), .din(din), .addr(addr),
    .en_n(en_n), .clr_n(clr_n), .q(q)
  );

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s: q=%b expected %b", tag, q, exp);
    end
  endtask

  // One cycle: drive at negedge, check the in-cycle output, update the model at the edge.
  // R1 mode codes (en_n,clr_n): 01 write, 11 hold, 00 decode, 10 clear
  task automatic step(input string tag, input logic e, input logic c,
                      input logic [2:0] a, input logic d, input logic r);
    logic [7:0] exp;
    @(negedge clk);
    en_n = e; clr_n = c; addr = a; din = d; rst = r;
    #2;
    case ({e, c})
      2'b00:   begin exp = '0; exp[a] = d; end
      2'b10:   exp = '0;
      default: exp = model;
    endcase
    if (!r) check(tag, exp);
    @(posedge clk);
    if (r || !c) model = '0;
    else if (!e) model[a] = d;
  endtask

  task automatic t_reset();
    step("R8 reset hold", 1, 1, 3'd5, 1, 0);
  endtask

  task automatic t_write_all();
    for (int i = 0; i < 8; i++)
      step("R2 R9 write", 0, 1, 3'(i), 1'($urandom_range(0, 1)), 0);
    step("R2 R3 readback", 1, 1, 3'd0, 0, 0);
    for (int i = 7; i >= 0; i--)
      step("R3 write reverse", 0, 1, 3'(i), 1'($urandom_range(0, 1)), 0);
    step("R2 R3 readback2", 1, 1, 3'd2, 1, 0);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 8; i++)
      step("R4 hold", 1, 1, 3'(i), 1'($urandom_range(0, 1)), 0);
  endtask

  task automatic t_decode();
    for (int i = 0; i < 8; i++) begin
      step("R5 decode d1", 0, 0, 3'(i), 1, 0);
      step("R5 decode rand", 0, 0, 3'(i), 1'($urandom_range(0, 1)), 0);
    end
  endtask

  task automatic t_decode_clears();
    for (int i = 0; i < 8; i++) step("R2 fill", 0, 1, 3'(i), 1, 0);
    step("R9 filled", 1, 1, 3'd0, 0, 0);
    step("R5 decode", 0, 0, 3'd6, 1, 0);
    step("R6 after decode", 1, 1, 3'd6, 1, 0);
  endtask

  task automatic t_clear();
    for (int i = 0; i < 8; i++) step("R2 fill", 0, 1, 3'(i), 1, 0);
    for (int i = 0; i < 8; i++)
      step("R7 clear", 1, 0, 3'(i), 1'($urandom_range(0, 1)), 0);
    step("R7 after clear", 1, 1, 3'd1, 1, 0);
  endtask

  task automatic t_reset_dominates();
    for (int i = 0; i < 8; i++) step("R2 fill", 0, 1, 3'(i), 1, 0);
    step("R8 rst in write", 0, 1, 3'd3, 1, 1);
    step("R8 after rst", 1, 1, 3'd3, 1, 0);
    step("R1 write after rst", 0, 1, 3'd4, 1, 0);
    step("R1 R2 readback", 1, 1, 3'd0, 0, 0);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_write_all();
    t_hold();
    t_decode();
    t_decode_clears();
    t_clear();
    t_reset_dominates();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: done=0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule